// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block judges each received frame by its 48-bit destination address. The six address bytes arrive one per cycle on a byte strobe. A start strobe marks the first byte. The block compares the bytes against a programmed station address and folds them into a CRC at the same time. In the cycle after the sixth byte it presents a registered verdict, together with broadcast and multicast indicators.

Configuration comes in as static inputs. These are the station address (a low word and a high half-word), a 64-bit hash table split into two 32-bit words, and seven mode controls. The checks run in a fixed priority order:

1. promiscuous mode,
2. broadcast blocking,
3. accept-all-multicast,
4. perfect or inverse matching, or the hash table lookup, chosen separately for unicast and multicast destinations.

A receive-all control passes frames that fail the filter, and the filter-fail flag stays raised for those frames.

Top module: `eth_da_filter`

## Requirements
- R1: After a synchronous active-low reset, dec_vld_o, pass_o, ok_o, fail_o, bcast_o and mcast_o are all 0.
- R2: A byte is taken when byte_vld_i is 1 and either sof_i is 1 (the byte becomes byte 0 and any partial address is abandoned) or fewer than six bytes have been taken since the last start. dec_vld_o is 1 for exactly the one cycle after the sixth byte is taken. Bytes offered after the sixth byte without sof_i are ignored.
- R3: When promisc_i is 1, ok_o is 1 whatever the address and the other controls.
- R4: An address of six 0xFF bytes is broadcast. bcast_o is 1 and mcast_o is 0. Unless promiscuous, the frame is accepted exactly when bcast_dis_i is 0, and this takes precedence over every multicast, perfect and hash rule.
- R5: A non-broadcast address whose byte 0 has bit 0 set is multicast (mcast_o = 1). When mcast_all_i is 1, every such frame is accepted.
- R6: Perfect matching compares byte 0..3 with sta_lo_i[7:0], [15:8], [23:16], [31:24] and byte 4..5 with sta_hi_i[7:0], [15:8]. It applies to multicast when mcast_hash_i is 0 and to unicast when ucast_hash_i is 0, and it accepts on an exact match of all six bytes.
- R7: When inv_match_i is 1, perfect matching accepts exactly when the address differs from the station address.
- R8: Hash matching applies to multicast when mcast_hash_i is 1 and to unicast when ucast_hash_i is 1. A CRC register is preset to all ones. The six bytes are shifted in least significant bit first with the reflected polynomial 0xEDB88320 and no final inversion. Index = CRC[31:26]. Index bit 5 = 1 selects hash_hi_i and 0 selects hash_lo_i; index bits 4:0 pick the bit, and the frame is accepted when that bit is 1.
- R9: fail_o is the inverse of ok_o. pass_o is 1 when ok_o is 1 or rx_all_i is 1, so a receive-all frame that fails is passed with fail_o raised.
- R10: The verdict outputs (pass_o, ok_o, fail_o, bcast_o, mcast_o) keep their values until the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_i | input | 1 | Marks the byte on byte_i as address byte 0 |
| byte_vld_i | input | 1 | byte_i carries an address byte this cycle |
| byte_i | input | 8 | Destination address byte |
| sta_lo_i | input | 32 | Station address bytes 0..3 (byte 0 in bits 7:0) |
| sta_hi_i | input | 16 | Station address bytes 4..5 (byte 4 in bits 7:0) |
| hash_hi_i | input | 32 | Hash table, bins 32..63 |
| hash_lo_i | input | 32 | Hash table, bins 0..31 |
| promisc_i | input | 1 | Accept every frame |
| bcast_dis_i | input | 1 | Reject broadcast frames |
| mcast_all_i | input | 1 | Accept every multicast frame |
| mcast_hash_i | input | 1 | Multicast uses hash instead of perfect match |
| ucast_hash_i | input | 1 | Unicast uses hash instead of perfect match |
| inv_match_i | input | 1 | Invert the perfect-match result |
| rx_all_i | input | 1 | Pass frames that fail the filter |
| dec_vld_o | output | 1 | One-cycle strobe: a new verdict is on the outputs |
| pass_o | output | 1 | Frame is to be passed on |
| ok_o | output | 1 | Frame passed the filter |
| fail_o | output | 1 | Frame failed the filter |
| bcast_o | output | 1 | Destination was broadcast |
| mcast_o | output | 1 | Destination was multicast (not broadcast) |

## Verification
A byte counter that slips, or one that is not cleared by a start strobe, shows at the ports as a missing, doubled or early dec_vld_o. The bench sees this in the very cycle the strobe should rise. A stale match, all-ones or group flag carried over from an earlier address, or a CRC not reseeded, flips ok_o only on the next verdict. For that reason the bench sends addresses that differ from the one before in exactly the bit under test, and compares every output on every cycle with a behavioural model.

// File: rtl/eth_da_filter_pkg.sv
// Package: shared constants, the mode bundle and the CRC byte step.
// Assumes bytes are fed to the CRC least significant bit first.
package eth_da_filter_pkg;

    localparam int unsigned CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // Mode controls gathered at the top level
    typedef struct packed {
        logic promisc;
        logic bcast_dis;
        logic mcast_all;
        logic mcast_hash;
        logic ucast_hash;
        logic inv_match;
        logic rx_all;
    } da_mode_t;

    // One byte of the reflected CRC, LSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] seed,
                                                  input logic [7:0] data);
        logic [CRC_W-1:0] c;
        c = seed;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ data[b]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/da_byte_track.sv
// da_byte_track: counts address bytes, compares them with the station
// address and tracks the all-ones and group flags. It assumes the station
// address is stable while an address is arriving. The flags it emits are
// the values that include the current byte, so the verdict can be formed
// in the cycle of the last byte.
module da_byte_track #(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sof_i,
    input  logic                         vld_i,
    input  logic [BYTE_W-1:0]            byte_i,
    input  logic [ADDR_BYTES*BYTE_W-1:0] sta_i,
    output logic                         take_o,
    output logic                         first_o,
    output logic                         last_o,
    output logic                         match_o,
    output logic                         ones_o,
    output logic                         grp_o
);
    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
    localparam int unsigned IDX_W = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    logic [BYTE_W-1:0] sta_b [ADDR_BYTES];
    logic [CNT_W-1:0]  cnt_q, idx;
    logic              eq_q, ones_q, grp_q;

    // Split the station address into byte lanes
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign sta_b[g] = sta_i[g*BYTE_W +: BYTE_W];
    end

    // Byte position and acceptance of the current byte
    always_comb begin
        idx     = sof_i ? '0 : cnt_q;
        take_o  = vld_i && (sof_i || (cnt_q != IDLE));
        first_o = sof_i;
        last_o  = take_o && (idx == LAST);
    end

    // Running flags including the current byte
    always_comb begin
        match_o = (sof_i ? 1'b1 : eq_q) && (byte_i == sta_b[idx[IDX_W-1:0]]);
        ones_o  = (sof_i ? 1'b1 : ones_q) && (&byte_i);
        grp_o   = sof_i ? byte_i[0] : grp_q;
    end

    // Advance the counter and hold the flags per taken byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= IDLE;
            eq_q   <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take_o) begin
            cnt_q  <= idx + 1'b1;
            eq_q   <= match_o;
            ones_q <= ones_o;
            grp_q  <= grp_o;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == IDLE && !sof_i) |=> (cnt_q == IDLE)); // R2
    AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o); // R2

endmodule

// File: rtl/da_crc_acc.sv
// da_crc_acc: accumulates the CRC over the address bytes and exposes the
// hash index computed from the value that includes the current byte.
// It assumes take/first come from the byte tracker.
module da_crc_acc
    import eth_da_filter_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             first_i,
    input  logic [7:0]       byte_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [CRC_W-1:0] crc_q, crc_nx;

    // Reseed on a start, then fold in the byte
    always_comb begin
        crc_nx = crc_step(first_i ? '1 : crc_q, byte_i);
        idx_o  = crc_nx[CRC_W-1 -: IDX_W];
    end

    // Keep the partial CRC between bytes
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= '1;
        else if (take_i) crc_q <= crc_nx;
    end

    AST_CRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(crc_q)); // R8

endmodule

// File: rtl/da_verdict.sv
// da_verdict: applies the filter rules in priority order on the last
// address byte and registers the verdict and indicators. It assumes the
// mode and hash table are stable in the cycle of the last byte.
module da_verdict
    import eth_da_filter_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  last_i,
    input  logic                  match_i,
    input  logic                  ones_i,
    input  logic                  grp_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [2**IDX_W-1:0]   table_i,
    input  da_mode_t              mode_i,
    output logic                  vld_o,
    output logic                  pass_o,
    output logic                  ok_o,
    output logic                  fail_o,
    output logic                  bcast_o,
    output logic                  mcast_o
);
    logic use_hash, ok_nx;

    // Rule ladder: promiscuous, broadcast, all-multicast, hash or perfect
    always_comb begin
        use_hash = grp_i ? mode_i.mcast_hash : mode_i.ucast_hash;
        if (mode_i.promisc)                ok_nx = 1'b1;
        else if (ones_i)                   ok_nx = !mode_i.bcast_dis;
        else if (grp_i && mode_i.mcast_all) ok_nx = 1'b1;
        else if (use_hash)                 ok_nx = table_i[idx_i];
        else                               ok_nx = match_i ^ mode_i.inv_match;
    end

    // Register the verdict on the last byte, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            pass_o  <= 1'b0;
            ok_o    <= 1'b0;
            fail_o  <= 1'b0;
            bcast_o <= 1'b0;
            mcast_o <= 1'b0;
        end else begin
            vld_o <= last_i;
            if (last_i) begin
                ok_o    <= ok_nx;
                fail_o  <= !ok_nx;
                pass_o  <= ok_nx || mode_i.rx_all;
                bcast_o <= ones_i;
                mcast_o <= grp_i && !ones_i;
            end
        end
    end

    AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && mode_i.promisc) |=> ok_o); // R3
    AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && ones_i && mode_i.bcast_dis && !mode_i.promisc) |=> !ok_o); // R4
    AST_RXALL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && mode_i.rx_all) |=> pass_o); // R9
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> ($stable(ok_o) && $stable(pass_o) && $stable(bcast_o))); // R10

endmodule

// File: rtl/eth_da_filter.sv
// eth_da_filter: destination address filter top. It ties the byte
// tracker, the CRC accumulator and the verdict stage together. It assumes
// configuration inputs change only between addresses.
module eth_da_filter
    import eth_da_filter_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_IDX_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sof_i,
    input  logic                              byte_vld_i,
    input  logic [BYTE_W-1:0]                 byte_i,
    input  logic [31:0]                       sta_lo_i,
    input  logic [ADDR_BYTES*BYTE_W-33:0]     sta_hi_i,
    input  logic [2**(HASH_IDX_W-1)-1:0]      hash_hi_i,
    input  logic [2**(HASH_IDX_W-1)-1:0]      hash_lo_i,
    input  logic                              promisc_i,
    input  logic                              bcast_dis_i,
    input  logic                              mcast_all_i,
    input  logic                              mcast_hash_i,
    input  logic                              ucast_hash_i,
    input  logic                              inv_match_i,
    input  logic                              rx_all_i,
    output logic                              dec_vld_o,
    output logic                              pass_o,
    output logic                              ok_o,
    output logic                              fail_o,
    output logic                              bcast_o,
    output logic                              mcast_o
);
    localparam int unsigned STA_W = ADDR_BYTES * BYTE_W;
    localparam int unsigned TBL_W = 2 ** HASH_IDX_W;

    da_mode_t               mode;
    logic [STA_W-1:0]       sta;
    logic [TBL_W-1:0]       tbl;
    logic                   take, first, last, match, ones, grp;
    logic [HASH_IDX_W-1:0]  hidx;

    // Bundle configuration; high word holds the upper hash bins
    always_comb begin
        mode = '{promisc: promisc_i, bcast_dis: bcast_dis_i, mcast_all: mcast_all_i,
                 mcast_hash: mcast_hash_i, ucast_hash: ucast_hash_i,
                 inv_match: inv_match_i, rx_all: rx_all_i};
        sta  = {sta_hi_i, sta_lo_i};
        tbl  = {hash_hi_i, hash_lo_i};
    end

    da_byte_track #(.BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES)) u_track (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .vld_i(byte_vld_i),
        .byte_i(byte_i), .sta_i(sta), .take_o(take), .first_o(first),
        .last_o(last), .match_o(match), .ones_o(ones), .grp_o(grp)
    );

    da_crc_acc #(.IDX_W(HASH_IDX_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .take_i(take), .first_i(first),
        .byte_i(byte_i), .idx_o(hidx)
    );

    da_verdict #(.IDX_W(HASH_IDX_W)) u_verdict (
        .clk(clk), .rst_n(rst_n), .last_i(last), .match_i(match),
        .ones_i(ones), .grp_i(grp), .idx_i(hidx), .table_i(tbl),
        .mode_i(mode), .vld_o(dec_vld_o), .pass_o(pass_o), .ok_o(ok_o),
        .fail_o(fail_o), .bcast_o(bcast_o), .mcast_o(mcast_o)
    );

endmodule

// File: tb/tb_eth_da_filter.sv
// Bench: behavioural model compared every cycle, plus directed checks.
module tb_eth_da_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 1'b0, bvld = 1'b0;
    logic [7:0] bdat = '0;
    logic [31:0] sta_lo = 32'h33221102;
    logic [15:0] sta_hi = 16'h5544;
    logic [31:0] hhi = '0, hlo = '0;
    logic promisc = 0, bdis = 0, mall = 0, mhash = 0, uhash = 0, inv = 0, rxall = 0;
    logic dvld, pass, ok, fail, bc, mc;

    int tests = 0, fails = 0;
    bit finished = 0;
    string tag = "R1";

    localparam logic [47:0] STA   = 48'h5544_3322_1102;
    localparam logic [47:0] OTHER = 48'h5544_3322_1106;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0100_0100_5E01;

    always #2 clk = ~clk;

    eth_da_filter dut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(bvld), .byte_i(bdat),
        .sta_lo_i(sta_lo), .sta_hi_i(sta_hi), .hash_hi_i(hhi), .hash_lo_i(hlo),
        .promisc_i(promisc), .bcast_dis_i(bdis), .mcast_all_i(mall),
        .mcast_hash_i(mhash), .ucast_hash_i(uhash), .inv_match_i(inv),
        .rx_all_i(rxall), .dec_vld_o(dvld), .pass_o(pass), .ok_o(ok),
        .fail_o(fail), .bcast_o(bc), .mcast_o(mc)
    );

    // Hash index of an address (byte i in bits 8i+7:8i)
    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++)
            c = (c[0] ^ a[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c[31:26];
    endfunction

    // Filter rules applied to a finished address
    function automatic logic [2:0] judge(input logic [47:0] a);
        logic is_b, is_m, k;
        logic [63:0] t;
        t = {hhi, hlo};
        is_b = (a == BCAST);
        is_m = a[0];
        if (promisc) k = 1;
        else if (is_b) k = !bdis;
        else if (is_m && mall) k = 1;
        else if (is_m ? mhash : uhash) k = t[hidx(a)];
        else k = (a == {sta_hi, sta_lo}) != inv;
        return {k, is_b, is_m && !is_b};
    endfunction

    // Cycle model: counter, byte queue and held verdict
    int m_cnt = 6;
    logic [47:0] m_a;
    logic [5:0] m_out;  // {vld, pass, ok, fail, bcast, mcast}
    bit m_live = 0;
    always @(posedge clk) begin
        logic [2:0] j;
        if (!rst_n) begin
            m_cnt = 6; m_out = '0; m_live = 1;
        end else begin
            m_out[5] = 0;
            if (bvld && (sof || m_cnt < 6)) begin
                int ix;
                ix = sof ? 0 : m_cnt;
                m_a[8*ix +: 8] = bdat;
                m_cnt = ix + 1;
                if (ix == 5) begin
                    j = judge(m_a);
                    m_out = {1'b1, j[2] | rxall, j[2], !j[2], j[1], j[0]};
                end
            end
        end
        #1;
        if (m_live && !finished) begin
            tests++;
            if ({dvld, pass, ok, fail, bc, mc} !== m_out) begin
                fails++;
                $display("FAIL %s cycle model: got %b expected %b", tag,
                         {dvld, pass, ok, fail, bc, mc}, m_out);
            end
        end
    end

    task automatic chk(input string t, input logic [5:0] exp);
        tests++;
        if ({dvld, pass, ok, fail, bc, mc} !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", t, {dvld, pass, ok, fail, bc, mc}, exp);
        end
    endtask

    // Send n bytes of a (first with start), then idle; ends at the negedge after the last byte
    task automatic send(input logic [47:0] a, input int n = 6, input bit st = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bvld = 1; sof = st && (i == 0); bdat = a[8*i +: 8];
        end
        @(negedge clk);
        bvld = 0; sof = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            finished = 1;
            $finish;
        end
    end

    initial begin
        logic [5:0] hold;
        logic [5:0] ix;
        idle(3);
        tag = "R1"; chk("R1 reset", 6'b000000);
        rst_n = 1; idle(2);
        chk("R1 after reset idle", 6'b000000);

        tag = "R6";
        send(STA);   chk("R6 station match", 6'b111000);
        send(OTHER); chk("R6 mismatch rejected", 6'b100100);
        idle(2);     chk("R10 verdict held", 6'b000100);

        tag = "R7"; inv = 1;
        send(OTHER); chk("R7 inverse accepts mismatch", 6'b111000);
        send(STA);   chk("R7 inverse rejects match", 6'b100100);
        inv = 0;

        tag = "R4";
        send(BCAST); chk("R4 broadcast accepted", 6'b111010);
        bdis = 1; mall = 1;
        send(BCAST); chk("R4 broadcast blocked before multicast", 6'b100110);
        mall = 0;

        tag = "R3"; promisc = 1;
        send(BCAST); chk("R3 promiscuous overrides block", 6'b111010);
        send(OTHER); chk("R3 promiscuous unicast", 6'b111000);
        promisc = 0; bdis = 0;

        tag = "R5";
        send(MCAST); chk("R5 multicast perfect miss", 6'b100101);
        mall = 1;
        send(MCAST); chk("R5 all-multicast accepts", 6'b111001);
        mall = 0;

        tag = "R8"; uhash = 1;
        send(STA); chk("R8 empty table rejects station", 6'b100100);
        ix = hidx(OTHER);
        if (ix[5]) hhi = 32'd1 << ix[4:0]; else hlo = 32'd1 << ix[4:0];
        send(OTHER); chk("R8 single hash bin hit", 6'b111000);
        hhi = ~hhi; hlo = ~hlo;
        send(OTHER); chk("R8 all bins but the hit", 6'b100100);
        uhash = 0; mhash = 1; hhi = '1; hlo = '1;
        send(MCAST); chk("R8 multicast hash hit", 6'b111001);
        mhash = 0; hhi = '0; hlo = '0;

        tag = "R9"; rxall = 1;
        send(OTHER); chk("R9 receive-all passes failure", 6'b110100);
        send(STA);   chk("R9 receive-all match", 6'b111000);
        rxall = 0;

        tag = "R2";
        send(OTHER, 3); chk("R2 no verdict on partial", 6'b011000);
        send(STA);      chk("R2 restart gives one verdict", 6'b111000);
        hold = {1'b0, 5'b11000};
        send(BCAST, 3, 0); idle(1);
        chk("R2 trailing bytes ignored", hold);
        send(OTHER, 4);
        send(STA >> 32, 2, 0);
        chk("R2 resume mid-address", 6'b100100);
        idle(3);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule